// File: doc/BRIEF.md
# Serial Addressed Configuration Loader

This block takes a three-wire serial configuration stream (serial clock, serial data, load strobe) and distributes each received word into one of four holding latches. The wires are sampled in the system clock domain through a small synchronizer. Each rising edge of the serial clock shifts one data bit into a 21-bit shift register, most significant bit first.

A rising edge of the load strobe commits the shift register. The two lowest bits of the word are an address code that picks the destination latch. The 19 bits above them are the payload. The latches drive a reference-divider field, a pair of swallow/main counter fields, a function word and an initialization word. Writing the initialization latch also refreshes the function latch and emits a one-cycle counter-reset pulse.

A chip-enable input overrides the power-down and charge-pump-tristate controls that the function word otherwise sets.

Top module: `cfg_loader`

## Requirements
- R1: After reset every latch output is zero, `cnt_rst_o` is low, and with `chip_en_i` high both `pd_o` and `cp_hiz_o` are low.
- R2: Bits are shifted MSB first on serial clock rising edges. Address code 00 (word bits [1:0]) writes `ref_div_o` with word bits [15:2].
- R3: Address code 01 writes `a_cnt_o` with word bits [6:2] and `b_cnt_o` with word bits [19:7].
- R4: Address code 10 writes `func_o` with word bits [20:2].
- R5: Address code 11 writes both `init_o` and `func_o` with word bits [20:2], and pulses `cnt_rst_o` high for exactly one clock cycle.
- R6: A load changes only the latch selected by its address code; all other latch outputs hold their values.
- R7: Serial clock edges that arrive while the load strobe is high are ignored. A second load pulse with no low-strobe shifting in between commits the same word again.
- R8: When more than 21 bits are shifted before a load, only the last 21 bits take effect.
- R9: `pd_o` is high when `chip_en_i` is low or when `func_o[1]` (word bit 3) is set. `cp_hiz_o` is high when `pd_o` is high or when `func_o[2]` (word bit 4) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data, MSB first |
| le_i | input | 1 | Load strobe, rising edge commits |
| chip_en_i | input | 1 | Chip enable, low forces power-down |
| ref_div_o | output | 14 | Reference divider field |
| a_cnt_o | output | 5 | Swallow counter field |
| b_cnt_o | output | 13 | Main counter field |
| func_o | output | 19 | Function latch payload |
| init_o | output | 19 | Initialization latch payload |
| cnt_rst_o | output | 1 | One-cycle counter reset pulse |
| pd_o | output | 1 | Power-down control |
| cp_hiz_o | output | 1 | Charge-pump output tristate |

## Verification
The bench sends words that use all four address codes, and it checks that the untouched latches keep their values. A decoder that reversed the code bits, or that wrote more than one latch, would corrupt a neighbour.

It sends serial clocks while the strobe is high, with all-ones data, and then pulses the strobe again. A design that kept shifting would turn the word into code 11 and write the initialization latch.

Overlong bursts catch a register that is wider than 21 bits or that shifts LSB first. The counter-reset pulses are counted, which exposes a pulse that is missing or stretched. Toggling chip enable exposes any override that is lost or inverted.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  localparam int WORD_W   = 21;
  localparam int ADDR_W   = 2;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int REF_W    = 14;
  localparam int A_W      = 5;
  localparam int B_W      = 13;
  localparam int PD_BIT   = 1;
  localparam int TRI_BIT  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_AB   = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } latch_sel_e;
endpackage

// File: rtl/cfg_in_sync.sv
`timescale 1ns/1ps
module cfg_in_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o
);
  // stg[STAGES] is the one-cycle-old copy used for edge detection
  logic [N-1:0] stg [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s <= STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s <= STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o    = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~stg[STAGES];
endmodule

// File: rtl/cfg_shift.sv
`timescale 1ns/1ps
module cfg_shift #(
  parameter int W = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/cfg_latch_bank.sv
`timescale 1ns/1ps
module cfg_latch_bank
  import cfg_loader_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int RW = REF_W,
  parameter int AW = A_W,
  parameter int BW = B_W,
  localparam int PW = W - ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  word_i,
  output logic [RW-1:0] ref_o,
  output logic [AW-1:0] a_o,
  output logic [BW-1:0] b_o,
  output logic [PW-1:0] func_o,
  output logic [PW-1:0] init_o,
  output logic          cnt_rst_o
);
  latch_sel_e     sel;
  logic [PW-1:0]  pay;

  assign sel = latch_sel_e'(word_i[ADDR_W-1:0]);
  assign pay = word_i[W-1:ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o     <= '0;
      a_o       <= '0;
      b_o       <= '0;
      func_o    <= '0;
      init_o    <= '0;
      cnt_rst_o <= 1'b0;
    end else begin
      cnt_rst_o <= 1'b0;
      if (load_i) begin
        unique case (sel)
          SEL_REF:  ref_o <= pay[RW-1:0];
          SEL_AB: begin
            a_o <= pay[AW-1:0];
            b_o <= pay[AW+BW-1:AW];
          end
          SEL_FUNC: func_o <= pay;
          SEL_INIT: begin
            init_o    <= pay;
            func_o    <= pay;
            cnt_rst_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             le_i,
  input  logic             chip_en_i,
  output logic [REF_W-1:0] ref_div_o,
  output logic [A_W-1:0]   a_cnt_o,
  output logic [B_W-1:0]   b_cnt_o,
  output logic [PAY_W-1:0] func_o,
  output logic [PAY_W-1:0] init_o,
  output logic             cnt_rst_o,
  output logic             pd_o,
  output logic             cp_hiz_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_q, pin_rise;
  logic [WORD_W-1:0] sreg;
  logic shift_en, load;

  cfg_in_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({le_i, sdata_i, sclk_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise)
  );

  // shifting is frozen while the strobe is high
  assign shift_en = pin_rise[0] & ~pin_q[2];
  assign load     = pin_rise[2];

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .bit_i   (pin_q[1]),
    .word_o  (sreg)
  );

  cfg_latch_bank #(.W(WORD_W), .RW(REF_W), .AW(A_W), .BW(B_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .word_i    (sreg),
    .ref_o     (ref_div_o),
    .a_o       (a_cnt_o),
    .b_o       (b_cnt_o),
    .func_o    (func_o),
    .init_o    (init_o),
    .cnt_rst_o (cnt_rst_o)
  );

  assign pd_o     = ~chip_en_i | func_o[PD_BIT];
  assign cp_hiz_o = pd_o | func_o[TRI_BIT];
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_en_i,
  input logic [REF_W-1:0] ref_div_o,
  input logic [A_W-1:0]   a_cnt_o,
  input logic [B_W-1:0]   b_cnt_o,
  input logic [PAY_W-1:0] func_o,
  input logic [PAY_W-1:0] init_o,
  input logic             cnt_rst_o,
  input logic             pd_o,
  input logic             cp_hiz_o
);
  p_rst_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |=> !cnt_rst_o);

  p_init_mirrors_func_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_o != $past(init_o)) |-> (func_o == init_o));

  p_rst_keeps_counters_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |-> ($stable(ref_div_o) && $stable(a_cnt_o) && $stable(b_cnt_o)));

  p_one_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ref_div_o != $past(ref_div_o),
                {a_cnt_o, b_cnt_o} != $past({a_cnt_o, b_cnt_o}),
                (func_o != $past(func_o)) && (init_o == $past(init_o))}) <= 1);

  p_ce_override_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |-> (pd_o && cp_hiz_o));

  p_hiz_follows_pd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> cp_hiz_o);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chip_en_i (chip_en_i),
  .ref_div_o (ref_div_o),
  .a_cnt_o   (a_cnt_o),
  .b_cnt_o   (b_cnt_o),
  .func_o    (func_o),
  .init_o    (init_o),
  .cnt_rst_o (cnt_rst_o),
  .pd_o      (pd_o),
  .cp_hiz_o  (cp_hiz_o)
);

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0, chip_en = 1'b1;
  logic [13:0] ref_div;
  logic [4:0]  a_cnt;
  logic [12:0] b_cnt;
  logic [18:0] func, init;
  logic cnt_rst, pd, cp_hiz;

  always #2.5 clk = ~clk;

  cfg_loader dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .chip_en_i(chip_en), .ref_div_o(ref_div), .a_cnt_o(a_cnt), .b_cnt_o(b_cnt),
    .func_o(func), .init_o(init), .cnt_rst_o(cnt_rst), .pd_o(pd), .cp_hiz_o(cp_hiz)
  );

  typedef struct packed {
    logic [13:0] r;
    logic [4:0]  a;
    logic [12:0] b;
    logic [18:0] f;
    logic [18:0] i;
    logic        pd;
    logic        hz;
  } snap_t;

  snap_t  q[$];
  string  tag_q[$];
  event   chk_ev;
  int     total = 0, bad = 0;
  int     pulses = 0, exp_pulses = 0;
  bit     done = 0;

  logic [13:0] m_r = '0;
  logic [4:0]  m_a = '0;
  logic [12:0] m_b = '0;
  logic [18:0] m_f = '0, m_i = '0;

  function automatic void apply(logic [20:0] w);
    case (w[1:0])
      2'b00: m_r = w[15:2];
      2'b01: begin m_a = w[6:2]; m_b = w[19:7]; end
      2'b10: m_f = w[20:2];
      default: begin m_i = w[20:2]; m_f = w[20:2]; exp_pulses++; end
    endcase
  endfunction

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic push(string tag);
    snap_t s;
    s.r = m_r; s.a = m_a; s.b = m_b; s.f = m_f; s.i = m_i;
    s.pd = ~chip_en | m_f[1];
    s.hz = s.pd | m_f[2];
    q.push_back(s);
    tag_q.push_back(tag);
    -> chk_ev;
    cyc(1);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int k = n - 1; k >= 0; k--) begin
      sdata = v[k]; cyc(3);
      sclk = 1'b1;  cyc(3);
      sclk = 1'b0;  cyc(3);
    end
  endtask

  task automatic pulse_le();
    cyc(2); le = 1'b1; cyc(4); le = 1'b0; cyc(6);
  endtask

  task automatic write_word(logic [20:0] w, string tag);
    send_bits({11'b0, w}, 21);
    pulse_le();
    apply(w);
    push(tag);
  endtask

  // monitor: pop expected snapshot and compare against the ports
  task automatic cmp(string tag, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s/%s act=%h exp=%h", tag, req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        snap_t s;
        string t;
        s = q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "R2 ref",  {18'b0, ref_div}, {18'b0, s.r});
        cmp(t, "R3 a",    {27'b0, a_cnt},   {27'b0, s.a});
        cmp(t, "R3 b",    {19'b0, b_cnt},   {19'b0, s.b});
        cmp(t, "R4 func", {13'b0, func},    {13'b0, s.f});
        cmp(t, "R5 init", {13'b0, init},    {13'b0, s.i});
        cmp(t, "R9 pd",   {31'b0, pd},      {31'b0, s.pd});
        cmp(t, "R9 hiz",  {31'b0, cp_hiz},  {31'b0, s.hz});
      end
    end
  end

  always @(negedge clk) if (rst_ni && cnt_rst) pulses++;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_ni = 1'b1;
    cyc(2);
    push("R1");
    total++;
    if (cnt_rst !== 1'b0) begin bad++; $display("FAIL R1 cnt_rst act=%b exp=0", cnt_rst); end

    write_word({5'h1F, 14'h2A5C, 2'b00}, "R2");
    write_word({1'b0, 13'h1ABC, 5'h13, 2'b01}, "R3_R6");
    write_word({16'h0, 3'b010, 2'b10}, "R4_R9_pd");
    write_word({15'h0, 4'b0100, 2'b10}, "R4_R9_hiz");
    chip_en = 1'b0; cyc(1);
    push("R9_ce_low");
    chip_en = 1'b1; cyc(1);
    push("R9_ce_high");
    write_word({19'h5A5A1, 2'b11}, "R5_R6");

    // R8: four leading ones pushed out by a full word
    send_bits({7'b0, 4'hF, 5'h00, 14'h1234, 2'b00}, 25);
    pulse_le();
    apply({5'h00, 14'h1234, 2'b00});
    push("R8");

    // R7: load, then shift ones with the strobe high, then load again
    write_word({5'h00, 14'h0777, 2'b00}, "R7_a");
    cyc(2); le = 1'b1; cyc(4);
    send_bits(32'hFFFF_FFFF, 21);
    le = 1'b0; cyc(6);
    pulse_le();
    push("R7_b");

    write_word({19'h00003, 2'b11}, "R5_again");
    cyc(4);

    total++;
    if (pulses != exp_pulses) begin
      bad++;
      $display("FAIL R5 pulse count act=%0d exp=%0d", pulses, exp_pulses);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule